// File: doc/BRIEF.md
# Fractional-Ratio Clock-Enable Divider

This block turns a fast base clock into a sparse clock-enable stream whose average rate is the base rate scaled by 18/N and then divided by an integer D. The first stage is a phase accumulator that adds 18 every active cycle and fires whenever the running sum reaches N. The second stage counts those firings and emits one enable per D of them. Logic downstream runs on the base clock and qualifies its registers with `en_o`.

Three small fields are written through a simple strobe interface: the fractional value N, the integer divisor D, and a stop bit for each stage. Illegal values are refused: the held field keeps its old value and an error flag pulses. A legal divisor write raises `busy_o` for a fixed interval that covers the longest possible output period. Software opens the fractional stage first, then programs D, and waits for busy to fall before it relies on the output.

Top module: `frac_post_div`

## Requirements
- R1: After reset `en_o`, `busy_o` and `err_o` are low, both stages are stopped, N is 18 and D is 1.
- R2: A write with `addr_i`=0 loads N from `wdata_i`. `addr_i`=1 loads D. `addr_i`=2 loads the stop bits: bit 0 stops the fractional stage and bit 1 stops the integer stage. A write with `addr_i`=3 changes no output and no setting.
- R3: A write of N below 18 or above 35 is refused. N keeps its previous value and `err_o` is high for exactly the one cycle after the write edge.
- R4: A write of D equal to 0 is refused. D keeps its previous value and `err_o` pulses as in R3.
- R5: With both stages running, any window of N·D consecutive cycles holds exactly 18 cycles with `en_o` high. The average enable rate is therefore 18/(N·D) of the base clock.
- R6: While either stop bit is set, `en_o` stays low. This holds from the second cycle after the stop bit is set for the fractional stage, and from the first cycle for the integer stage.
- R7: A legal D write sets `busy_o` in the cycle after the write edge. Busy stays high for exactly ceil(35·255/18) = 496 cycles and then drops. Writes to other fields never raise it.
- R8: `err_o` is raised only by a refused write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 2 | Field select: 0 N, 1 D, 2 stop bits, 3 unused |
| wdata_i | input | 8 | Write data |
| en_o | output | 1 | Clock-enable pulse |
| busy_o | output | 1 | New divisor still settling |
| err_o | output | 1 | Previous write was refused |

## Verification
The assertions check the following on every cycle:
- N stays inside 18..35 and D stays non-zero.
- A stopped stage keeps `en_o` low.
- An illegal write produces an error pulse, and every error pulse traces back to a write.
- Busy only rises after a divisor write.

Only the bench's scenarios can show two things. The first is that the pulse count over an N·D window matches 18 for many (N, D) pairs. The second is that the busy interval has exactly the specified length. Refusals are shown by an unchanged output rate after the illegal write.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int FRAC_NUM = 18;
  localparam int N_MIN    = 18;
  localparam int N_MAX    = 35;
  localparam int NW       = 6;

  typedef enum logic [1:0] {
    ADDR_FRAC = 2'd0,
    ADDR_DIV  = 2'd1,
    ADDR_GATE = 2'd2,
    ADDR_RSVD = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/fpd_regs.sv
module fpd_regs
  import fpd_pkg::*;
#(
  parameter int DW       = 8,
  parameter int BUSY_CYC = 496
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [NW-1:0] n_o,
  output logic [DW-1:0] d_o,
  output logic          gate_frac_o,
  output logic          gate_post_o,
  output logic          n_load_o,
  output logic          d_load_o,
  output logic          err_o,
  output logic          busy_o
);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic [BW-1:0] busy_cnt_q;
  logic          n_ok, d_ok, wr_n, wr_d, wr_g;

  assign n_ok = (int'(wdata_i) >= N_MIN) && (int'(wdata_i) <= N_MAX);
  assign d_ok = (wdata_i != '0);
  assign wr_n = we_i && (cfg_addr_e'(addr_i) == ADDR_FRAC);
  assign wr_d = we_i && (cfg_addr_e'(addr_i) == ADDR_DIV);
  assign wr_g = we_i && (cfg_addr_e'(addr_i) == ADDR_GATE);

  assign n_load_o = wr_n && n_ok;
  assign d_load_o = wr_d && d_ok;
  assign busy_o   = (busy_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_o         <= NW'(N_MIN);
      d_o         <= DW'(1);
      gate_frac_o <= 1'b1;
      gate_post_o <= 1'b1;
      err_o       <= 1'b0;
      busy_cnt_q  <= '0;
    end else begin
      err_o <= (wr_n && !n_ok) || (wr_d && !d_ok);
      if (n_load_o) n_o <= wdata_i[NW-1:0];
      if (d_load_o) d_o <= wdata_i;
      if (wr_g) begin
        gate_frac_o <= wdata_i[0];
        gate_post_o <= wdata_i[1];
      end
      if (d_load_o)          busy_cnt_q <= BW'(BUSY_CYC);
      else if (busy_o)       busy_cnt_q <= busy_cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fpd_frac.sv
module fpd_frac
  import fpd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] n_i,
  input  logic          gate_i,
  input  logic          restart_i,
  output logic          tick_o
);
  logic [NW:0] acc_q, sum;

  // acc < N <= 35, so acc + 18 fits in NW+1 bits
  assign sum = acc_q + (NW+1)'(FRAC_NUM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (restart_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (gate_i) begin
      tick_o <= 1'b0;
    end else if (sum >= {1'b0, n_i}) begin
      acc_q  <= sum - {1'b0, n_i};
      tick_o <= 1'b1;
    end else begin
      acc_q  <= sum;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fpd_post.sv
module fpd_post #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] d_i,
  input  logic          gate_i,
  input  logic          restart_i,
  output logic          en_o
);
  logic [DW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == d_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_o  <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      en_o  <= 1'b0;
    end else begin
      en_o <= 1'b0;
      if (!gate_i && tick_i) begin
        if (last) begin
          cnt_q <= '0;
          en_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frac_post_div.sv
module frac_post_div
  import fpd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int BUSY_CYC = (N_MAX * ((1 << DIV_W) - 1) + FRAC_NUM - 1) / FRAC_NUM
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [DIV_W-1:0] wdata_i,
  output logic             en_o,
  output logic             busy_o,
  output logic             err_o
);
  logic [NW-1:0]    n_q;
  logic [DIV_W-1:0] d_q;
  logic             gate_frac, gate_post, n_load, d_load, tick;

  fpd_regs #(.DW(DIV_W), .BUSY_CYC(BUSY_CYC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .n_o        (n_q),
    .d_o        (d_q),
    .gate_frac_o(gate_frac),
    .gate_post_o(gate_post),
    .n_load_o   (n_load),
    .d_load_o   (d_load),
    .err_o      (err_o),
    .busy_o     (busy_o)
  );

  fpd_frac u_frac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .n_i      (n_q),
    .gate_i   (gate_frac),
    .restart_i(n_load),
    .tick_o   (tick)
  );

  fpd_post #(.DW(DIV_W)) u_post (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .d_i      (d_q),
    .gate_i   (gate_post),
    .restart_i(d_load),
    .en_o     (en_o)
  );
endmodule

// File: rtl/fpd_chk.sv
module fpd_chk
  import fpd_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          en_o,
  input logic          busy_o,
  input logic          err_o,
  input logic [NW-1:0] n_q,
  input logic [DW-1:0] d_q,
  input logic          gate_frac,
  input logic          gate_post
);
  a_r3_n_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(n_q) >= N_MIN) && (int'(n_q) <= N_MAX));

  a_r4_d_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_q != '0);

  a_r3_err_on_bad_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0 && (int'(wdata_i) < N_MIN || int'(wdata_i) > N_MAX)) |=> err_o);

  a_r4_err_on_zero_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1 && wdata_i == '0) |=> err_o);

  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(we_i));

  a_r6_post_gate_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_post |=> !en_o);

  a_r6_frac_gate_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_frac && $past(gate_frac)) |=> !en_o);

  a_r7_busy_after_div_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1 && wdata_i != '0) |=> busy_o);

  a_r7_busy_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(we_i && addr_i == 2'd1));
endmodule

bind frac_post_div fpd_chk #(.DW(DIV_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .en_o     (en_o),
  .busy_o   (busy_o),
  .err_o    (err_o),
  .n_q      (n_q),
  .d_q      (d_q),
  .gate_frac(gate_frac),
  .gate_post(gate_post)
);

// File: tb/frac_post_div_tb.sv
module frac_post_div_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       en_o, busy_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int BUSY_EXP = (35 * 255 + 17) / 18;

  always #4 clk_i = ~clk_i;

  frac_post_div u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .en_o   (en_o),
    .busy_o (busy_o),
    .err_o  (err_o)
  );

  function automatic int exp_pulses(int k);
    return 18 * k;
  endfunction

  function automatic int win_mult(int n, int d);
    return (n * d < 600) ? 4 : 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int v);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 2'(a); wdata_i = 8'(v);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic count_en(int w, output int c);
    c = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk_i);
      if (en_o) c++;
    end
  endtask

  task automatic setup(int n, int d);
    wr(0, n);
    wr(2, 0);
    wr(1, d);
    wait_idle();
  endtask

  task automatic rate_check(int n, int d, string req);
    int c, k;
    k = win_mult(n, d);
    count_en(n * d * k, c);
    check(c == exp_pulses(k), req, c, exp_pulses(k));
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c, bc;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check(en_o == 0, "R1 en", en_o, 0);
    check(busy_o == 0, "R1 busy", busy_o, 0);
    check(err_o == 0, "R1 err", err_o, 0);
    rst_ni = 1'b1;
    count_en(200, c);
    check(c == 0, "R1 stopped after reset", c, 0);
    // open stages with reset N=18, D=1: enable every cycle
    wr(2, 0);
    repeat (4) @(negedge clk_i);
    rate_check(18, 1, "R1 R5 reset N18 D1");

    // busy interval R7
    wr(0, 20);
    check(busy_o == 0, "R7 no busy on N write", busy_o, 0);
    wr(1, 2);
    bc = 0;
    while (busy_o && bc < 2000) begin bc++; @(negedge clk_i); end
    check(bc == BUSY_EXP, "R7 busy length", bc, BUSY_EXP);
    wait_idle();
    rate_check(20, 2, "R5 N20 D2");

    // refused N R3
    wr(0, 17);
    check(err_o == 1, "R3 err on 17", err_o, 1);
    @(negedge clk_i);
    check(err_o == 0, "R3 err single", err_o, 0);
    rate_check(20, 2, "R3 N kept after 17");
    wr(0, 36);
    check(err_o == 1, "R3 err on 36", err_o, 1);
    rate_check(20, 2, "R3 N kept after 36");

    // refused D R4
    wr(1, 0);
    check(err_o == 1, "R4 err on zero", err_o, 1);
    check(busy_o == 0, "R4 no busy on zero", busy_o, 0);
    rate_check(20, 2, "R4 D kept");

    // unused address R2 R8
    wr(3, 8'hff);
    check(err_o == 0, "R8 no err on addr3", err_o, 0);
    check(busy_o == 0, "R2 no busy on addr3", busy_o, 0);
    rate_check(20, 2, "R2 addr3 no effect");
    wr(0, 25);
    check(err_o == 0, "R8 no err on legal N", err_o, 0);
    wait_idle();
    rate_check(25, 2, "R2 N field load");

    // stop bits R6
    wr(2, 1);
    repeat (2) @(negedge clk_i);
    count_en(300, c);
    check(c == 0, "R6 frac stop", c, 0);
    wr(2, 2);
    @(negedge clk_i);
    count_en(300, c);
    check(c == 0, "R6 post stop", c, 0);
    wr(2, 0);
    repeat (4) @(negedge clk_i);
    rate_check(25, 2, "R6 resume");

    // directed corners R5
    setup(35, 255);
    rate_check(35, 255, "R5 N35 D255");
    setup(19, 3);
    rate_check(19, 3, "R5 N19 D3");
    setup(18, 255);
    rate_check(18, 255, "R5 N18 D255");

    // random configs R5
    for (int i = 0; i < 7; i++) begin
      int n, d;
      n = 18 + int'($urandom % 18);
      d = 1 + int'($urandom % 200);
      setup(n, d);
      rate_check(n, d, $sformatf("R5 rand N%0d D%0d", n, d));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule